// File: doc/BRIEF.md
# Bus Break-Point Comparator

This block sits beside a processor bus and watches each access beat. It has two comparator channels, A and B. Each channel holds a reference address and a reference data value, each with a don't-care mask, plus a filter on the kind of access and a filter on the transfer size. A beat that passes every enabled test of a channel is a hit on that channel. A hit is turned into a one-cycle break request for the debug logic.

Two modes are available. In independent mode a hit on either channel raises the break. In sequential mode a hit on channel A only arms the unit and does not break. A later hit on channel B while the unit is armed raises the break and disarms it. Each channel also keeps a sticky hit flag, which debug software clears through the configuration port.

Configuration is written one register at a time. `cfg_ch` selects the channel and `cfg_sel` selects the register.

Top module: `bus_brk_unit`

## Requirements
- R1: After reset, `brk_req`, `hit_a`, `hit_b` and `armed` are 0, both channels are disabled and the unit is in independent mode.
- R2: The address compare passes when every bit of `bus_addr` equals the reference address (`cfg_sel`=0) wherever the address mask (`cfg_sel`=1) holds 0. A mask bit of 1 always matches.
- R3: The data compare passes when every bit of `bus_data` equals the reference data (`cfg_sel`=2) wherever the data mask (`cfg_sel`=3) holds 0. A mask bit of 1 always matches.
- R4: The control register (`cfg_sel`=4) has a kind field in bits [1:0]: 0 fetch, 1 read, 2 write, 3 any. The compare passes when the field is 3 or equals `bus_kind`, which is coded 0 fetch, 1 read, 2 write.
- R5: The control register has a size field in bits [3:2]: 0 byte, 1 word, 2 longword, 3 any. The compare passes when the field is 3 or equals `bus_size`, which uses the same coding.
- R6: In independent mode (mode register `cfg_sel`=6, bit0=0), a beat that hits either channel sets `brk_req` high for exactly the one cycle after the beat.
- R7: In sequential mode (mode bit0=1), a hit on channel A sets `armed` in the cycle after the beat and does not raise `brk_req`.
- R8: In sequential mode, a hit on channel B raises `brk_req` and clears `armed` only when `armed` was already set. A channel B hit while disarmed has no effect on `brk_req`, `armed` or `hit_b`.
- R9: `hit_a` and `hit_b` are set by a hit that counts for that channel and then stay set. A status write (`cfg_sel`=5) with bit0=0 clears the selected channel's flag. With bit0=1 the flag is left unchanged.
- R10: A beat with `bus_valid` low, or on a channel whose control enable bit [4] is 0, never produces a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus beat is present this cycle |
| bus_addr | input | AW | Beat address |
| bus_data | input | DW | Beat data |
| bus_kind | input | 2 | 0 fetch, 1 read, 2 write |
| bus_size | input | 2 | 0 byte, 1 word, 2 longword |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Target channel: 0 = A, 1 = B |
| cfg_sel | input | 3 | Register select (0..6) |
| cfg_wdata | input | CW | Write data |
| brk_req | output | 1 | One-cycle break request |
| hit_a | output | 1 | Sticky channel A hit flag |
| hit_b | output | 1 | Sticky channel B hit flag |
| armed | output | 1 | Sequential mode: channel A has been seen |

## Verification
The bench checks the edges of the masks. A bit one position outside the mask must still cause a miss, so a design that widened the mask or inverted its polarity would break on the wrong addresses. In sequential mode the bench presents B before A, then A, then B, then B again. This ordering exposes a design that breaks on B without being armed, never disarms, or lets A alone break. The bench also checks that a status write with bit0 set leaves a flag alone and that a disabled channel or an idle bus is ignored, which catches clear-on-any-write and missing qualification.

// File: rtl/bus_brk_unit.sv
module bus_brk_unit #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data,
  input  logic [1:0]    bus_kind,
  input  logic [1:0]    bus_size,
  input  logic          cfg_we,
  input  logic          cfg_ch,
  input  logic [2:0]    cfg_sel,
  input  logic [CW-1:0] cfg_wdata,
  output logic          brk_req,
  output logic          hit_a,
  output logic          hit_b,
  output logic          armed
);
  localparam logic [2:0] SEL_ADDR = 3'd0, SEL_AMSK = 3'd1, SEL_DATA = 3'd2,
                         SEL_DMSK = 3'd3, SEL_CTRL = 3'd4, SEL_STAT = 3'd5,
                         SEL_MODE = 3'd6;

  logic [AW-1:0] c_addr  [2];
  logic [AW-1:0] c_amask [2];
  logic [DW-1:0] c_data  [2];
  logic [DW-1:0] c_dmask [2];
  logic [4:0]    c_ctrl  [2];
  logic [1:0]    match, clr, hit, en_vec;
  logic          seq_mode, fire_b, brk_next;

  for (genvar g = 0; g < 2; g++) begin : g_ch
    wire sel_me = cfg_we && (cfg_ch == 1'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        c_addr[g]  <= '0;
        c_amask[g] <= '0;
        c_data[g]  <= '0;
        c_dmask[g] <= '0;
        c_ctrl[g]  <= '0;
      end else if (sel_me) begin
        case (cfg_sel)
          SEL_ADDR: c_addr[g]  <= cfg_wdata[AW-1:0];
          SEL_AMSK: c_amask[g] <= cfg_wdata[AW-1:0];
          SEL_DATA: c_data[g]  <= cfg_wdata[DW-1:0];
          SEL_DMSK: c_dmask[g] <= cfg_wdata[DW-1:0];
          SEL_CTRL: c_ctrl[g]  <= cfg_wdata[4:0];
          default: ;
        endcase
      end
    end

    wire addr_ok = ((bus_addr ^ c_addr[g]) & ~c_amask[g]) == '0;
    wire data_ok = ((bus_data ^ c_data[g]) & ~c_dmask[g]) == '0;
    wire kind_ok = (c_ctrl[g][1:0] == 2'd3) || (c_ctrl[g][1:0] == bus_kind);
    wire size_ok = (c_ctrl[g][3:2] == 2'd3) || (c_ctrl[g][3:2] == bus_size);

    assign en_vec[g] = c_ctrl[g][4];
    assign match[g]  = bus_valid && en_vec[g] && addr_ok && data_ok && kind_ok && size_ok;
    assign clr[g]    = sel_me && (cfg_sel == SEL_STAT) && !cfg_wdata[0];
  end

  assign fire_b   = seq_mode ? (match[1] && armed) : match[1];
  assign brk_next = seq_mode ? fire_b : (match[0] || match[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_mode <= 1'b0;
      armed    <= 1'b0;
      brk_req  <= 1'b0;
      hit      <= '0;
    end else begin
      brk_req <= brk_next;
      hit     <= {fire_b, match[0]} | (hit & ~clr);
      if (cfg_we && cfg_sel == SEL_MODE) begin
        seq_mode <= cfg_wdata[0];
        armed    <= 1'b0;
      end else if (seq_mode) begin
        armed <= match[0] || (armed && !match[1]);
      end
    end
  end

  assign hit_a = hit[0];
  assign hit_b = hit[1];
endmodule

module brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_valid,
  input logic       brk_req,
  input logic       armed,
  input logic       seq_mode,
  input logic       hit_a,
  input logic       cfg_we,
  input logic [1:0] en_vec
);
  AST_BRK_NEEDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> $past(bus_valid) && ($past(en_vec) != 2'b00)); // R10
  AST_SEQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req && $past(seq_mode) |-> $past(armed)); // R8
  AST_ARM_ONLY_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> seq_mode); // R7
  AST_HIT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hit_a) && !$past(cfg_we) |-> hit_a); // R9
endmodule

bind bus_brk_unit brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .brk_req(brk_req),
  .armed(armed), .seq_mode(seq_mode), .hit_a(hit_a), .cfg_we(cfg_we),
  .en_vec(en_vec)
);

// File: tb/sim_bus_brk_unit.sv
`timescale 1ns/1ps
module sim_bus_brk_unit;
  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0;
  logic [31:0] bus_addr = 0, bus_data = 0;
  logic [1:0]  bus_kind = 0, bus_size = 0;
  logic        cfg_we = 0, cfg_ch = 0;
  logic [2:0]  cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic        brk_req, hit_a, hit_b, armed;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  bus_brk_unit u0 (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(input logic ch, input logic [2:0] sel, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_ch = ch; cfg_sel = sel; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic setup(input logic ch, input logic [31:0] a, am, d, dm, input logic [4:0] c);
    wr(ch, 0, a); wr(ch, 1, am); wr(ch, 2, d); wr(ch, 3, dm); wr(ch, 4, {27'd0, c});
  endtask

  task automatic beat(input logic [31:0] a, d, input logic [1:0] k, s, input logic v = 1);
    @(negedge clk);
    bus_valid = v; bus_addr = a; bus_data = d; bus_kind = k; bus_size = s;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic clean;
    setup(0, 0, 0, 0, 0, 0); setup(1, 0, 0, 0, 0, 0);
    wr(0, 6, 0); wr(0, 5, 0); wr(1, 5, 0);
  endtask

  task automatic t_reset;
    chk("R1 brk", brk_req, 0); chk("R1 hit_a", hit_a, 0);
    chk("R1 hit_b", hit_b, 0); chk("R1 armed", armed, 0);
    beat(0, 0, 0, 0); chk("R1 disabled after reset", brk_req, 0);
  endtask

  task automatic t_addr;
    clean; setup(0, 32'h1000, 0, 0, '1, 5'h1F);
    beat(32'h1000, 7, 1, 2); chk("R2 exact", brk_req, 1);
    beat(32'h1004, 7, 1, 2); chk("R2 miss", brk_req, 0);
    wr(0, 1, 32'hF);
    beat(32'h100C, 7, 1, 2); chk("R2 masked", brk_req, 1);
    beat(32'h1010, 7, 1, 2); chk("R2 outside mask", brk_req, 0);
  endtask

  task automatic t_data;
    clean; setup(1, 0, '1, 32'hAB, 32'hFFFF_FF00, 5'h1F);
    beat(32'h55, 32'h55AB, 2, 0); chk("R3 data hit", brk_req, 1);
    beat(32'h55, 32'h55AC, 2, 0); chk("R3 data miss", brk_req, 0);
  endtask

  task automatic t_kind;
    clean; setup(0, 0, '1, 0, '1, 5'b1_11_10);
    beat(4, 0, 2, 1); chk("R4 write hit", brk_req, 1);
    beat(4, 0, 1, 1); chk("R4 read miss", brk_req, 0);
    beat(4, 0, 0, 1); chk("R4 fetch miss", brk_req, 0);
  endtask

  task automatic t_size;
    clean; setup(0, 0, '1, 0, '1, 5'b1_01_11);
    beat(4, 0, 0, 1); chk("R5 word hit", brk_req, 1);
    beat(4, 0, 0, 2); chk("R5 long miss", brk_req, 0);
  endtask

  task automatic t_indep;
    clean; setup(0, 32'h10, 0, 0, '1, 5'h1F); setup(1, 32'h20, 0, 0, '1, 5'h1F);
    beat(32'h20, 0, 1, 2); chk("R6 B breaks", brk_req, 1);
    @(negedge clk); chk("R6 one-cycle pulse", brk_req, 0);
    beat(32'h10, 0, 1, 2); chk("R6 A breaks", brk_req, 1);
  endtask

  task automatic t_sticky;
    clean; setup(0, 32'h10, 0, 0, '1, 5'h1F);
    chk("R9 cleared", hit_a, 0);
    beat(32'h10, 0, 1, 2); @(negedge clk); chk("R9 set and held", hit_a, 1);
    wr(0, 5, 1); chk("R9 write one keeps", hit_a, 1);
    wr(1, 5, 0); chk("R9 other channel clear keeps", hit_a, 1);
    wr(0, 5, 0); chk("R9 write zero clears", hit_a, 0);
  endtask

  task automatic t_seq;
    clean; setup(0, 32'h10, 0, 0, '1, 5'h1F); setup(1, 32'h20, 0, 0, '1, 5'h1F);
    wr(0, 6, 1);
    beat(32'h20, 0, 1, 2); chk("R8 B unarmed no brk", brk_req, 0);
    chk("R8 B unarmed no hit_b", hit_b, 0); chk("R8 stays disarmed", armed, 0);
    beat(32'h10, 0, 1, 2); chk("R7 A no brk", brk_req, 0);
    chk("R7 armed", armed, 1); chk("R7 hit_a", hit_a, 1);
    beat(32'h20, 0, 1, 2); chk("R8 armed B breaks", brk_req, 1);
    chk("R8 disarmed", armed, 0); chk("R8 hit_b", hit_b, 1);
    beat(32'h20, 0, 1, 2); chk("R8 second B no brk", brk_req, 0);
  endtask

  task automatic t_qual;
    clean; setup(0, 32'h10, 0, 0, '1, 5'h0F);
    beat(32'h10, 0, 1, 2); chk("R10 disabled channel", brk_req, 0);
    chk("R10 disabled no flag", hit_a, 0);
    wr(0, 4, 32'h1F);
    beat(32'h10, 0, 1, 2, 0); chk("R10 idle bus", brk_req, 0);
    beat(32'h10, 0, 1, 2); chk("R10 enabled hits", brk_req, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_addr; t_data; t_kind; t_size;
    t_indep; t_sticky; t_seq; t_qual;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule